// File: doc/BRIEF.md
# Wait-State Memory Slave

This block is a small word-organised RAM that sits behind a status-based bus handshake. A requester raises a strobe together with a direction bit, a byte address and, for writes, a data word. The slave answers on a 2-bit status output. It can insert a fixed, parameterised number of wait states before it completes the access, and it reports an error at once for any access it cannot serve. The requester keeps presenting the same request while the status shows WAIT. The cycle in which the status reads OK is the cycle in which read data is valid and a write is committed.

A second, side-band port reaches the same storage with no wait states at all. It gives a pass/fail flag and read data in the same cycle, which makes it suitable for monitors or preloading. A read-only build option turns the storage into a ROM-like target: writes on both ports are refused.

Top module: `wsmem_slave`

## Requirements
- R1: After reset the status output is idle (2'b00), the direct pass flag is low while the direct port is unused, and every stored word reads as zero.
- R2: A request is legal only if its address is a multiple of four and lies between BASE_ADDR and BASE_ADDR+4*NUM_WORDS-1 inclusive. Any other request gets status ERROR (2'b11) in the cycle it is presented, starts no transfer and changes no stored word.
- R3: With WAIT_STATES = W > 0, a legal request shows status WAIT (2'b01) in the cycle it is first presented and in the following W-1 cycles, and shows status OK (2'b10) in the cycle after those, provided the strobe stays high throughout.
- R4: With zero wait states, a legal request shows OK in the same cycle it is presented, and WAIT never appears.
- R5: During the OK cycle of a read, the read data output carries the addressed word. In every other cycle, and for writes, it is zero.
- R6: A write takes effect at the clock edge that ends its OK cycle and is visible from the next cycle on. It has no effect earlier.
- R7: If the strobe drops while the status is WAIT, the transfer is abandoned. The status is idle in the next cycle and a pending write is discarded.
- R8: When READ_ONLY is set, a normal write returns ERROR, a direct write returns fail, and the stored word is unchanged. Reads still work.
- R9: The direct port answers in the same cycle, independent of any normal transfer in progress. Its pass flag is high exactly for an enabled, legal access. Read data is the addressed word, and a write is visible from the next cycle.
- R10: If a normal write (in its OK cycle) and a direct write hit the same word at the same edge, the normal write's data is kept.
- R11: After an OK cycle, a request still presented in the next cycle is treated as a fresh request and goes through the full wait sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Normal-port request strobe, held until status leaves WAIT |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the request |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the OK cycle of a read |
| status_o | output | 2 | 00 idle, 01 wait, 10 ok, 11 error |
| dir_en_i | input | 1 | Direct-port access enable |
| dir_wr_i | input | 1 | Direct-port direction, 1 = write |
| dir_addr_i | input | ADDR_W | Direct-port byte address |
| dir_wdata_i | input | DATA_W | Direct-port write data |
| dir_rdata_o | output | DATA_W | Direct-port read data |
| dir_ok_o | output | 1 | Direct-port pass flag |

## Verification
Several properties are checked on every cycle. No run of WAIT is ever longer than the configured wait count. An error or an OK always leaves the slave free in the next cycle, and a dropped strobe after WAIT gives idle. A write is committed only under OK, and the direct pass flag never rises without an enable or for a read-only write. Other behaviour can only be shown by the bench scenarios, because it needs knowledge of stored contents. This covers data integrity across a full sweep of the address range, the exact wait count, a discarded write after an abort, direct accesses during a normal transfer, and which data survives a write collision on one word.

// File: rtl/wsmem_pkg.sv
`timescale 1ns/1ps
package wsmem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_OK   = 2'b10,
        ST_ERR  = 2'b11
    } wsm_status_e;
endpackage

// File: rtl/wsmem_decode.sv
`timescale 1ns/1ps
// Address legality check and word index for one access port.
module wsmem_decode #(
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 32'h80,
    parameter int NUM_WORDS = 32,
    parameter int IDX_W     = 5,
    parameter bit READ_ONLY = 1'b0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output logic              legal_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [ADDR_W:0] LO_A = (ADDR_W+1)'(BASE_ADDR);
    localparam logic [ADDR_W:0] HI_A = (ADDR_W+1)'(BASE_ADDR + NUM_WORDS*4 - 1);

    logic [ADDR_W:0] ext;
    logic [ADDR_W:0] off;
    logic            hit;

    always_comb begin
        ext     = {1'b0, addr_i};
        off     = ext - LO_A;
        hit     = (ext >= LO_A) && (ext <= HI_A) && (addr_i[1:0] == 2'b00);
        legal_o = hit && !(wr_i && READ_ONLY);
        idx_o   = hit ? IDX_W'(off >> 2) : '0;
    end
endmodule

// File: rtl/wsmem_ctl.sv
`timescale 1ns/1ps
// Wait-state sequencer: status generation and commit strobe.
module wsmem_ctl
    import wsmem_pkg::*;
#(
    parameter int WAIT_STATES = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        legal_i,
    output wsm_status_e status_o,
    output logic        commit_o
);
    localparam int CNT_W = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'((WAIT_STATES > 0) ? WAIT_STATES - 1 : 0);
    localparam bit ZERO_WAIT = (WAIT_STATES == 0);
    localparam int RUN_W = $clog2(WAIT_STATES + 2);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d    = ctl_q;
        status_o = ST_IDLE;
        commit_o = 1'b0;
        if (!ctl_q.busy) begin
            if (req_i) begin
                if (!legal_i) begin
                    status_o = ST_ERR;
                end else if (ZERO_WAIT) begin
                    status_o = ST_OK;
                    commit_o = 1'b1;
                end else begin
                    status_o   = ST_WAIT;
                    ctl_d.busy = 1'b1;
                    ctl_d.cnt  = CNT_LOAD;
                end
            end
        end else begin
            if (!req_i) begin
                ctl_d.busy = 1'b0;
            end else if (ctl_q.cnt == '0) begin
                status_o   = ST_OK;
                commit_o   = 1'b1;
                ctl_d.busy = 1'b0;
            end else begin
                status_o  = ST_WAIT;
                ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Length of the current run of WAIT cycles, for the bound check.
    logic [RUN_W-1:0] run_d, run_q;
    always_comb run_d = (status_o == ST_WAIT) ? run_q + 1'b1 : '0;
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    AST_WAIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(WAIT_STATES)); // R3
    AST_WAIT_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == ST_WAIT) |=> (status_o != ST_ERR)); // R3
    AST_ERR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == ST_ERR) |=> !ctl_q.busy); // R2
    AST_OK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == ST_OK) |=> !ctl_q.busy); // R11
    AST_ZERO_NOWAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ZERO_WAIT |-> (status_o != ST_WAIT)); // R4
    AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == ST_WAIT) ##1 !req_i |-> (status_o == ST_IDLE)); // R7
endmodule

// File: rtl/wsmem_store.sv
`timescale 1ns/1ps
// Word storage with a normal and a direct port; normal write wins a collision.
module wsmem_store #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 32,
    parameter int IDX_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we_i,
    input  logic [IDX_W-1:0]  a_idx_i,
    input  logic [DATA_W-1:0] a_wdata_i,
    output logic [DATA_W-1:0] a_rdata_o,
    input  logic              b_we_i,
    input  logic [IDX_W-1:0]  b_idx_i,
    input  logic [DATA_W-1:0] b_wdata_i,
    output logic [DATA_W-1:0] b_rdata_o
);
    logic [NUM_WORDS-1:0][DATA_W-1:0] words_q;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [DATA_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (b_we_i && (b_idx_i == IDX_W'(w))) word_d = b_wdata_i;
            if (a_we_i && (a_idx_i == IDX_W'(w))) word_d = a_wdata_i;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign words_q[w] = word_q;
    end

    assign a_rdata_o = words_q[a_idx_i];
    assign b_rdata_o = words_q[b_idx_i];
endmodule

// File: rtl/wsmem_slave.sv
`timescale 1ns/1ps
module wsmem_slave
    import wsmem_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int BASE_ADDR   = 32'h80,
    parameter int NUM_WORDS   = 32,
    parameter int WAIT_STATES = 1,
    parameter bit READ_ONLY   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [1:0]        status_o,
    input  logic              dir_en_i,
    input  logic              dir_wr_i,
    input  logic [ADDR_W-1:0] dir_addr_i,
    input  logic [DATA_W-1:0] dir_wdata_i,
    output logic [DATA_W-1:0] dir_rdata_o,
    output logic              dir_ok_o
);
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    logic              n_legal, d_legal;
    logic [IDX_W-1:0]  n_idx, d_idx;
    logic [DATA_W-1:0] n_rd, d_rd;
    logic              commit;
    logic              n_we, d_we;
    wsm_status_e       st;

    wsmem_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_WORDS(NUM_WORDS),
        .IDX_W(IDX_W), .READ_ONLY(READ_ONLY)
    ) u_dec_norm (
        .addr_i(addr_i), .wr_i(wr_i), .legal_o(n_legal), .idx_o(n_idx)
    );

    wsmem_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_WORDS(NUM_WORDS),
        .IDX_W(IDX_W), .READ_ONLY(READ_ONLY)
    ) u_dec_dir (
        .addr_i(dir_addr_i), .wr_i(dir_wr_i), .legal_o(d_legal), .idx_o(d_idx)
    );

    wsmem_ctl #(.WAIT_STATES(WAIT_STATES)) u_ctl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .legal_i(n_legal),
        .status_o(st), .commit_o(commit)
    );

    assign n_we     = commit && wr_i;
    assign dir_ok_o = dir_en_i && d_legal;
    assign d_we     = dir_ok_o && dir_wr_i;

    wsmem_store #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_we_i(n_we), .a_idx_i(n_idx), .a_wdata_i(wdata_i), .a_rdata_o(n_rd),
        .b_we_i(d_we), .b_idx_i(d_idx), .b_wdata_i(dir_wdata_i), .b_rdata_o(d_rd)
    );

    assign status_o    = st;
    assign rdata_o     = ((st == ST_OK) && !wr_i) ? n_rd : '0;
    assign dir_rdata_o = (dir_ok_o && !dir_wr_i) ? d_rd : '0;

    AST_COMMIT_UNDER_OK: assert property (@(posedge clk) disable iff (!rst_n)
        n_we |-> (status_o == 2'b10)); // R6
    AST_DIR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        dir_ok_o |-> dir_en_i); // R9
    AST_DIR_RO_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (READ_ONLY && dir_en_i && dir_wr_i) |-> !dir_ok_o); // R8
endmodule

// File: tb/wsmem_slave_tb.sv
`timescale 1ns/1ps
module wsmem_slave_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk; // 250 MHz

    // index 0: dut_i (3 wait states, writable); index 1: dut_z (0 wait states, read-only)
    logic        req[2], wr[2], den[2], dwr[2], dok[2];
    logic [15:0] addr[2], daddr[2];
    logic [31:0] wdata[2], rdata[2], dwdata[2], drdata[2];
    logic [1:0]  status[2];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    wsmem_slave #(.WAIT_STATES(3), .READ_ONLY(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req[0]), .wr_i(wr[0]), .addr_i(addr[0]),
        .wdata_i(wdata[0]), .rdata_o(rdata[0]), .status_o(status[0]),
        .dir_en_i(den[0]), .dir_wr_i(dwr[0]), .dir_addr_i(daddr[0]),
        .dir_wdata_i(dwdata[0]), .dir_rdata_o(drdata[0]), .dir_ok_o(dok[0]));

    wsmem_slave #(.WAIT_STATES(0), .READ_ONLY(1'b1)) dut_z (
        .clk(clk), .rst_n(rst_n), .req_i(req[1]), .wr_i(wr[1]), .addr_i(addr[1]),
        .wdata_i(wdata[1]), .rdata_o(rdata[1]), .status_o(status[1]),
        .dir_en_i(den[1]), .dir_wr_i(dwr[1]), .dir_addr_i(daddr[1]),
        .dir_wdata_i(dwdata[1]), .dir_rdata_o(drdata[1]), .dir_ok_o(dok[1]));

    function automatic logic [31:0] pat(int i, int salt);
        return (32'(i) * 32'h0101_0101) ^ 32'(salt);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic nop(input int k, input logic w, input logic [15:0] a, input logic [31:0] d,
                       output logic [1:0] st, output logic [31:0] rd, output int nw);
        @(negedge clk);
        req[k] = 1'b1; wr[k] = w; addr[k] = a; wdata[k] = d; nw = 0;
        #1; st = status[k];
        while (st == 2'b01 && nw < 50) begin
            nw++;
            @(negedge clk); #1; st = status[k];
        end
        rd = rdata[k];
    endtask

    task automatic dop(input int k, input logic w, input logic [15:0] a, input logic [31:0] d,
                       output logic ok, output logic [31:0] rd);
        @(negedge clk);
        den[k] = 1'b1; dwr[k] = w; daddr[k] = a; dwdata[k] = d;
        #1; ok = dok[k]; rd = drdata[k];
        @(negedge clk);
        den[k] = 1'b0;
    endtask

    task automatic idle(input int k);
        @(negedge clk);
        req[k] = 1'b0; den[k] = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [1:0]  st;
        logic [31:0] rd;
        logic        ok;
        int          nw;
        logic [15:0] bad [5] = '{16'h007C, 16'h0100, 16'h0082, 16'h0000, 16'hFFFC};

        for (int k = 0; k < 2; k++) begin
            req[k] = 0; wr[k] = 0; den[k] = 0; dwr[k] = 0;
            addr[k] = 0; daddr[k] = 0; wdata[k] = 0; dwdata[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 status idle dut_i", 32'(status[0]), 32'h0);
        chk("R1 status idle dut_z", 32'(status[1]), 32'h0);
        chk("R1 direct flag low", 32'(dok[0]), 32'h0);
        chk("R1 rdata zero", rdata[0], 32'h0);
        dop(0, 1'b0, 16'h0080, 0, ok, rd); chk("R1 word0 zero", rd, 32'h0);
        dop(0, 1'b0, 16'h00FC, 0, ok, rd); chk("R1 word31 zero", rd, 32'h0);

        // R3 R6 R11: back-to-back writes over the whole range
        for (int i = 0; i < 32; i++) begin
            nop(0, 1'b1, 16'(16'h80 + 4*i), pat(i, 1), st, rd, nw);
            chk("R3 wait count on write", 32'(nw), 32'd3);
            chk("R11 status ok after waits", 32'(st), 32'h2);
            chk("R5 rdata zero on write", rd, 32'h0);
        end
        idle(0);

        // R9 direct reads see the written pattern
        for (int i = 0; i < 32; i++) begin
            dop(0, 1'b0, 16'(16'h80 + 4*i), 0, ok, rd);
            chk("R9 direct pass", 32'(ok), 32'h1);
            chk("R9 direct data", rd, pat(i, 1));
        end

        // R5 normal reads in reverse order
        for (int i = 31; i >= 0; i--) begin
            nop(0, 1'b0, 16'(16'h80 + 4*i), 0, st, rd, nw);
            chk("R3 wait count on read", 32'(nw), 32'd3);
            chk("R5 read data", rd, pat(i, 1));
        end
        idle(0);

        // R2 illegal addresses
        for (int j = 0; j < 5; j++) begin
            nop(0, 1'b1, bad[j], 32'hBAD0_0000, st, rd, nw);
            chk("R2 error status", 32'(st), 32'h3);
            chk("R2 no wait on error", 32'(nw), 32'd0);
            dop(0, 1'b0, bad[j], 0, ok, rd);
            chk("R2 direct fail out of range", 32'(ok), 32'h0);
        end
        idle(0);
        #1; chk("R2 idle after error", 32'(status[0]), 32'h0);
        dop(0, 1'b0, 16'h0080, 0, ok, rd); chk("R2 word0 untouched", rd, pat(0, 1));

        // R7 abort a write during WAIT
        @(negedge clk); req[0] = 1; wr[0] = 1; addr[0] = 16'h009C; wdata[0] = 32'hDEAD_BEEF;
        #1; chk("R7 wait before abort", 32'(status[0]), 32'h1);
        @(negedge clk); req[0] = 0;
        #1; chk("R7 idle after drop", 32'(status[0]), 32'h0);
        dop(0, 1'b0, 16'h009C, 0, ok, rd); chk("R7 write discarded", rd, pat(7, 1));

        // R9 direct write while a normal read waits
        @(negedge clk); req[0] = 1; wr[0] = 0; addr[0] = 16'h0088;
        #1; chk("R3 wait on accept", 32'(status[0]), 32'h1);
        chk("R5 rdata zero during wait", rdata[0], 32'h0);
        @(negedge clk); den[0] = 1; dwr[0] = 1; daddr[0] = 16'h00A4; dwdata[0] = 32'h1234_5678;
        #1; chk("R9 direct pass during wait", 32'(dok[0]), 32'h1);
        chk("R9 normal still waiting", 32'(status[0]), 32'h1);
        @(negedge clk); den[0] = 0;
        #1; chk("R3 third wait", 32'(status[0]), 32'h1);
        @(negedge clk); #1;
        chk("R3 ok after three waits", 32'(status[0]), 32'h2);
        chk("R5 read data after direct", rdata[0], pat(2, 1));
        @(negedge clk); req[0] = 0;
        dop(0, 1'b0, 16'h00A4, 0, ok, rd); chk("R9 direct write visible", rd, 32'h1234_5678);

        // R6 R10 collision on word 5
        @(negedge clk); req[0] = 1; wr[0] = 1; addr[0] = 16'h0094; wdata[0] = 32'hAAAA_0005;
        @(negedge clk); @(negedge clk);
        #1; dop(0, 1'b0, 16'h0094, 0, ok, rd); // runs during OK cycle
        chk("R6 old data before commit", rd, pat(5, 1));
        // restart a clean write then collide in its OK cycle
        idle(0);
        @(negedge clk); req[0] = 1; wr[0] = 1; addr[0] = 16'h0094; wdata[0] = 32'hAAAA_0005;
        @(negedge clk); @(negedge clk); @(negedge clk);
        den[0] = 1; dwr[0] = 1; daddr[0] = 16'h0094; dwdata[0] = 32'hBBBB_0005;
        #1; chk("R10 ok in collision cycle", 32'(status[0]), 32'h2);
        chk("R10 direct pass in collision", 32'(dok[0]), 32'h1);
        @(negedge clk); req[0] = 0; den[0] = 0;
        dop(0, 1'b0, 16'h0094, 0, ok, rd); chk("R10 normal write kept", rd, 32'hAAAA_0005);

        // R4 R8 zero-wait read-only instance
        for (int i = 0; i < 32; i += 7) begin
            nop(1, 1'b0, 16'(16'h80 + 4*i), 0, st, rd, nw);
            chk("R4 ok same cycle", 32'(st), 32'h2);
            chk("R4 no wait cycles", 32'(nw), 32'd0);
            chk("R1 ro word zero", rd, 32'h0);
        end
        nop(1, 1'b1, 16'h0090, 32'h5555_5555, st, rd, nw);
        chk("R8 normal write error", 32'(st), 32'h3);
        idle(1);
        dop(1, 1'b1, 16'h0090, 32'h6666_6666, ok, rd);
        chk("R8 direct write fail", 32'(ok), 32'h0);
        dop(1, 1'b0, 16'h0090, 0, ok, rd);
        chk("R8 read still passes", 32'(ok), 32'h1);
        chk("R8 word unchanged", rd, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule